// File: doc/BRIEF.md
# Event FIFO Drain with Backlog Truncation

This block empties a show-ahead event FIFO toward a 20-bit link interface, one word per clock. Its clock runs at twice the bunch-crossing rate, so two short events can leave in the span of a single crossing. Each event in the FIFO is a header word followed by as many payload words as the header's length field announces. The reader takes the FIFO's empty flag, head word and event occupancy count, and returns a pop strobe plus a registered link word with a valid bit.

When the backlog is too deep, the reader truncates. If the FIFO still holds at least the truncation limit of events (448 by default) at the moment an event's header is taken, that event goes out as a bare header. Its truncate status bit is set and its length is cleared. Its payload words are still popped, so the FIFO keeps moving, but they are not sent. The decision is made again for every event, so normal output resumes as soon as the occupancy drops below the limit. A payload word takes one clock from FIFO to link, so the reader adds a single cycle to the latency that the FIFO backlog already imposes. In raw mode and in zero-suppressed mode alike, the remaining latency is set by the depth of that backlog.

Top module: `frd_event_reader`

## Requirements
- R1: While rst_n is low, fifo_rd is 0. After one clock edge in reset, link_valid is 0 and link_word is 0.
- R2: fifo_rd is never 1 while fifo_empty is 1.
- R3: Out of reset, the reader pops on every clock in which fifo_empty is 0. The word popped at an edge, or its replacement, appears on link_word after that same edge.
- R4: Header layout: bit 19 is the upset flag, bit 18 the zero-suppression flag, bit 17 the truncate flag, bits 16:12 the payload length in words (0 to 31), and bits 11:0 the crossing number. When fifo_count is below the limit as the header is popped, the header is forwarded unchanged with valid high. Its payload words then follow, one per clock, unchanged and in order.
- R5: When fifo_count is at or above the limit as a header is popped, the link shows that header with bit 17 set, bits 16:12 cleared and every other bit unchanged. The original length's worth of payload words are then popped, and during those cycles link_valid is 0 and link_word is 0.
- R6: Truncation is decided per event. The first header popped with fifo_count below the limit after a truncated event is forwarded normally.
- R7: In a cycle with no pop, the next link_word is 0 and link_valid is 0.
- R8: A length-0 event occupies exactly one link cycle. Back-to-back headers appear on consecutive clocks, which is two events per crossing at the doubled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reader clock, twice the bunch-crossing rate |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rdata | input | 20 | FIFO head word (show-ahead) |
| fifo_count | input | CNT_W | Number of complete events held in the FIFO |
| fifo_rd | output | 1 | Pop the head word at this edge |
| link_word | output | 20 | Word toward the link |
| link_valid | output | 1 | link_word carries a header or payload word |

## Verification
The bench builds the reader with a 5-bit occupancy count and a truncation limit of 6, so a burst of under ten events crosses the limit in both directions. It sweeps the length field over all 32 values with single events. It then sweeps burst sizes 1 to 9 against lengths 0 to 3, so that every occupancy from 1 to 9 meets the truncation decision. A final run keeps adding events while the reader drains. Expected words come from a model of the FIFO in the bench that tracks occupancy at each pop.

// File: rtl/frd_pkg.sv
// Package: shared field layout and slot kinds for the event FIFO reader.
// Assumes a 20-bit word whose header layout is fixed by the downstream decoder.
package frd_pkg;
    localparam int WORD_W = 20;
    localparam int LEN_W  = 5;
    localparam int BX_W   = 12;

    // Header word as seen on the FIFO and on the link (MSB first).
    typedef struct packed {
        logic             upset;
        logic             zsup;
        logic             trunc;
        logic [LEN_W-1:0] len;
        logic [BX_W-1:0]  bx;
    } evt_hdr_t;

    // What the reader does with the current clock slot.
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_HDR  = 2'd1,
        SLOT_DATA = 2'd2,
        SLOT_DROP = 2'd3
    } slot_kind_t;
endpackage

// File: rtl/frd_trunc_judge.sv
// Module: frd_trunc_judge
// Decides whether the event whose header is at the FIFO head is truncated.
// It also produces the header as it must appear on the link.
// Assumes fifo_count counts complete events, the one at the head included.
module frd_trunc_judge #(
    parameter int CNT_W       = 10,
    parameter int TRUNC_LIMIT = 448
) (
    input  logic [CNT_W-1:0]          fifo_count,
    input  logic [frd_pkg::WORD_W-1:0] hdr_in,
    output logic                      over,
    output logic [frd_pkg::WORD_W-1:0] hdr_out
);
    import frd_pkg::*;

    localparam longint MAX_CNT = (longint'(1) << CNT_W) - 1;

    // Pick the comparator variant: a limit above the count range never trips.
    generate
        if (longint'(TRUNC_LIMIT) > MAX_CNT) begin : g_never
            assign over = 1'b0;
        end else begin : g_cmp
            localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(TRUNC_LIMIT);
            assign over = (fifo_count >= LIMIT_C);
        end
    endgenerate

    evt_hdr_t hin, hout;
    assign hin = evt_hdr_t'(hdr_in);

    // Rewrite the header for a truncated event: flag set, length cleared.
    always_comb begin
        hout = hin;
        if (over) begin
            hout.trunc = 1'b1;
            hout.len   = '0;
        end
    end

    assign hdr_out = hout;
endmodule

// File: rtl/frd_frame_seq.sv
// Module: frd_frame_seq
// Tracks event framing (header, then len payload words) and pops every
// available word. It marks each slot as idle, header, payload or dropped.
// Assumes a show-ahead FIFO and well-formed events.
module frd_frame_seq (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fifo_empty,
    input  logic [frd_pkg::LEN_W-1:0]   hdr_len,
    input  logic                        over,
    output logic                        pop,
    output frd_pkg::slot_kind_t         kind
);
    import frd_pkg::*;

    logic [LEN_W-1:0] rem_q, rem_d;
    logic             drop_q, drop_d;

    // Next-state and slot classification for the word at the FIFO head.
    always_comb begin
        pop    = rst_n && !fifo_empty;
        kind   = SLOT_IDLE;
        rem_d  = rem_q;
        drop_d = drop_q;
        if (pop) begin
            if (rem_q == '0) begin
                kind   = SLOT_HDR;
                rem_d  = hdr_len;
                drop_d = over;
            end else begin
                kind  = drop_q ? SLOT_DROP : SLOT_DATA;
                rem_d = rem_q - LEN_W'(1);
            end
        end
    end

    // Framing state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            drop_q <= 1'b0;
        end else begin
            rem_q  <= rem_d;
            drop_q <= drop_d;
        end
    end
endmodule

// File: rtl/frd_link_reg.sv
// Module: frd_link_reg
// Output register toward the link: it shows the header or payload word
// for the slot just taken, or the all-zero idle word with valid low.
module frd_link_reg (
    input  logic                         clk,
    input  logic                         rst_n,
    input  frd_pkg::slot_kind_t          kind,
    input  logic [frd_pkg::WORD_W-1:0]   hdr_word,
    input  logic [frd_pkg::WORD_W-1:0]   data_word,
    output logic [frd_pkg::WORD_W-1:0]   link_word,
    output logic                         link_valid
);
    import frd_pkg::*;

    logic [WORD_W-1:0] word_d;
    logic              valid_d;

    // Select the word for this slot.
    always_comb begin
        word_d  = '0;
        valid_d = 1'b0;
        case (kind)
            SLOT_HDR:  begin word_d = hdr_word;  valid_d = 1'b1; end
            SLOT_DATA: begin word_d = data_word; valid_d = 1'b1; end
            default:   begin word_d = '0;        valid_d = 1'b0; end
        endcase
    end

    // Register the link outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_word  <= '0;
            link_valid <= 1'b0;
        end else begin
            link_word  <= word_d;
            link_valid <= valid_d;
        end
    end
endmodule

// File: rtl/frd_event_reader.sv
// Module: frd_event_reader (top)
// Drains a show-ahead event FIFO at one word per clock toward a 20-bit link.
// Events popped while occupancy is at or above TRUNC_LIMIT leave as a bare
// header with the truncate flag set; their payload is popped and discarded.
// Assumes the clock is twice the crossing rate and events are well formed.
module frd_event_reader #(
    parameter int CNT_W       = 10,
    parameter int TRUNC_LIMIT = 448
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_empty,
    input  logic [19:0]                fifo_rdata,
    input  logic [CNT_W-1:0]           fifo_count,
    output logic                       fifo_rd,
    output logic [19:0]                link_word,
    output logic                       link_valid
);
    import frd_pkg::*;

    logic              over;
    logic [WORD_W-1:0] hdr_link;
    slot_kind_t        kind;
    evt_hdr_t          head_hdr;

    assign head_hdr = evt_hdr_t'(fifo_rdata);

    frd_trunc_judge #(
        .CNT_W       (CNT_W),
        .TRUNC_LIMIT (TRUNC_LIMIT)
    ) u_judge (
        .fifo_count (fifo_count),
        .hdr_in     (fifo_rdata),
        .over       (over),
        .hdr_out    (hdr_link)
    );

    frd_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .hdr_len    (head_hdr.len),
        .over       (over),
        .pop        (fifo_rd),
        .kind       (kind)
    );

    frd_link_reg u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .hdr_word   (hdr_link),
        .data_word  (fifo_rdata),
        .link_word  (link_word),
        .link_valid (link_valid)
    );
endmodule

// File: rtl/frd_event_reader_chk.sv
// Module: frd_event_reader_chk
// Checker bound to frd_event_reader. It keeps its own framing count from
// the port activity and checks the link against it.
module frd_event_reader_chk #(
    parameter int CNT_W       = 10,
    parameter int TRUNC_LIMIT = 448
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_empty,
    input logic [19:0]      fifo_rdata,
    input logic [CNT_W-1:0] fifo_count,
    input logic             fifo_rd,
    input logic [19:0]      link_word,
    input logic             link_valid
);
    logic [4:0]  c_rem;
    logic        c_drop;
    logic        c_pop_q, c_hdr_q, c_full_q, c_drop_q;
    logic [19:0] c_word_q;
    logic        full_now;

    assign full_now = ({1'b0, fifo_count} >= (CNT_W+1)'(TRUNC_LIMIT));

    // Shadow framing state and one-cycle history of the pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_rem    <= '0;
            c_drop   <= 1'b0;
            c_pop_q  <= 1'b0;
            c_hdr_q  <= 1'b0;
            c_full_q <= 1'b0;
            c_drop_q <= 1'b0;
            c_word_q <= '0;
        end else begin
            c_pop_q  <= fifo_rd;
            c_hdr_q  <= fifo_rd && (c_rem == 0);
            c_full_q <= full_now;
            c_drop_q <= fifo_rd && (c_rem != 0) && c_drop;
            c_word_q <= fifo_rdata;
            if (fifo_rd) begin
                if (c_rem == 0) begin
                    c_rem  <= fifo_rdata[16:12];
                    c_drop <= full_now;
                end else begin
                    c_rem <= c_rem - 5'd1;
                end
            end
        end
    end

    AST_RD_WHEN_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty); // R2
    AST_DRAIN_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty |-> fifo_rd); // R3
    AST_VALID_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |-> c_pop_q); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !link_valid |-> (link_word == 20'd0)); // R7
    AST_CLEAN_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hdr_q && !c_full_q) |-> (link_valid && link_word == c_word_q)); // R4
    AST_TRUNC_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hdr_q && c_full_q) |-> (link_valid && link_word[17] && link_word[16:12] == 5'd0)); // R5
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        c_drop_q |-> !link_valid); // R5
endmodule

bind frd_event_reader frd_event_reader_chk #(
    .CNT_W       (CNT_W),
    .TRUNC_LIMIT (TRUNC_LIMIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .fifo_count (fifo_count),
    .fifo_rd    (fifo_rd),
    .link_word  (link_word),
    .link_valid (link_valid)
);

// File: tb/sim_frd_event_reader.sv
// Bench for frd_event_reader: a FIFO model feeds events; a reference model
// computes each link word from the requirements and the modelled occupancy.
module sim_frd_event_reader;
    localparam int CNT_W = 5;
    localparam int LIMIT = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_empty;
    logic [19:0]      fifo_rdata;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_rd;
    logic [19:0]      link_word;
    logic             link_valid;

    logic [20:0] q [0:255];
    logic [7:0]  qh = 8'd0, qt = 8'd0;
    int          ev_cnt = 0;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    logic [19:0] exp_word = '0;
    logic        exp_valid = 1'b0;
    string       exp_tag = "R7";
    bit          pend_pop = 1'b0;
    int          m_rem = 0;
    bit          m_drop = 1'b0, prev_trunc = 1'b0, prev_hdr = 1'b0;

    always #2 clk = ~clk;

    assign fifo_empty = (qh == qt);
    assign fifo_rdata = q[qh][19:0];
    assign fifo_count = CNT_W'(ev_cnt);

    frd_event_reader #(.CNT_W(CNT_W), .TRUNC_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty),
        .fifo_rdata(fifo_rdata), .fifo_count(fifo_count), .fifo_rd(fifo_rd),
        .link_word(link_word), .link_valid(link_valid)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [20:0] act, input logic [20:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_event(input int len, input int k);
        q[qt] = {1'b1, k[0], k[1], 1'b0, 5'(len), 12'(k)};
        qt = qt + 8'd1;
        ev_cnt++;
        for (int i = 0; i < len; i++) begin
            q[qt] = {1'b0, 20'(k * 37 + i * 11 + 20'h5a5a0)};
            qt = qt + 8'd1;
        end
    endtask

    // Decide the expected pop and link word for the coming edge.
    task automatic plan_next();
        logic [20:0] e;
        bit over;
        #1;
        if (qh != qt) begin
            chk(fifo_rd == 1'b1, "R3 pop when available", {20'd0, fifo_rd}, 21'd1);
            e = q[qh];
            if (m_rem == 0) begin
                over = (ev_cnt >= LIMIT);
                exp_valid = 1'b1;
                exp_word = over ? {e[19:18], 1'b1, 5'd0, e[11:0]} : e[19:0];
                exp_tag = over ? "R5 trunc header" :
                          (prev_trunc ? "R6 recovery header" :
                          (prev_hdr ? "R8 back-to-back header" : "R4 header"));
                m_rem = int'(e[16:12]);
                m_drop = over;
                prev_trunc = over;
                prev_hdr = 1'b1;
            end else begin
                m_rem--;
                exp_valid = !m_drop;
                exp_word = m_drop ? 20'd0 : e[19:0];
                exp_tag = m_drop ? "R5 dropped payload" : "R4 payload";
                prev_hdr = 1'b0;
            end
            pend_pop = 1'b1;
        end else begin
            chk(fifo_rd == 1'b0, "R2 no pop when empty", {20'd0, fifo_rd}, 21'd0);
            exp_valid = 1'b0;
            exp_word = '0;
            exp_tag = "R7 idle";
            prev_hdr = 1'b0;
            pend_pop = 1'b0;
        end
    endtask

    // Cross the edge, apply the modelled pop and compare the link.
    task automatic tick_and_check();
        @(negedge clk);
        if (pend_pop) begin
            if (q[qh][20]) ev_cnt--;
            qh = qh + 8'd1;
        end
        chk(link_valid == exp_valid && link_word == exp_word, exp_tag,
            {link_valid, link_word}, {exp_valid, exp_word});
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) begin
            plan_next();
            tick_and_check();
        end
    endtask

    initial begin
        // R1: reset holds the reader even with data waiting.
        push_event(0, 7);
        repeat (3) @(negedge clk);
        #1;
        chk(fifo_rd == 1'b0, "R1 no pop in reset", {20'd0, fifo_rd}, 21'd0);
        chk(link_valid == 1'b0 && link_word == 20'd0, "R1 reset outputs",
            {link_valid, link_word}, 21'd0);
        @(negedge clk);
        rst_n = 1'b1;
        advance(4);

        // Single events over every length value (R4, R8 for length 0).
        for (int len = 0; len < 32; len++) begin
            push_event(len, len + 100);
            advance(len + 3);
        end

        // Burst size against length: occupancy crosses the limit (R5, R6).
        for (int b = 1; b <= 9; b++) begin
            for (int len = 0; len < 4; len++) begin
                for (int k = 0; k < b; k++) push_event(len, b * 16 + len * 4 + k);
                advance(b * (len + 1) + 3);
            end
        end

        // Arrivals while draining.
        for (int k = 0; k < 8; k++) push_event(2, 500 + k);
        for (int k = 0; k < 10; k++) begin
            push_event(k % 3, 600 + k);
            advance(1);
        end
        advance(60);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R3 watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule